// File: doc/BRIEF.md
# Return-to-Zero Request/Acknowledge Bus Link

This block pairs an initiating controller with a responding controller. Between them runs a shared address and data bus that carries single-word reads and writes. No transfer clock crosses the link. Each transfer is sequenced by two wires only, a request from the initiator and an acknowledge from the responder. Both wires return to zero before the next transfer may begin.

The initiator needs bus ownership before it acts. It then drives the address and the direction, plus the write data for a write. It lets the address decode settle for a fixed number of cycles and only then raises request. The responder is backed by a small register file. On a write, it stores the bus data and raises acknowledge to show the data has been taken. On a read, it places the addressed word on the bus and raises acknowledge to show the word is valid. The initiator drops request once it sees acknowledge, capturing the read word at that moment. The responder drops acknowledge once it sees request low. Only then does the initiator release the bus and pulse done.

Both controllers sit in one clock domain. Each one synchronizes the handshake wire it receives through a chain of flip-flops, so the pair behaves as it would across a true asynchronous boundary.

Top module: `rtz_link_top`

## Requirements
- R1: A command is accepted only in a cycle where `own_bus` is high. While `own_bus` is low, `cmd_valid` is ignored: `addr_drive` and `bus_req` stay low, and the register file is unchanged.
- R2: `bus_req` rises exactly `DECODE_CYC` clock cycles (default 2) after `addr_drive` rises.
- R3: On a write (`cmd_write`=1), the responder stores `cmd_wdata` at `cmd_addr` before it raises `bus_ack`. `bus_ack` rises only while `bus_req` is high.
- R4: On a read (`cmd_write`=0), `xfer_rdata` shown with `xfer_done` equals the last value written to that address.
- R5: `bus_req` falls only while `bus_ack` is high.
- R6: `bus_ack` falls only while `bus_req` is low.
- R7: `addr_drive` falls, and `xfer_done` is given, only after `bus_ack` has fallen. A new `addr_drive` never starts while `bus_ack` is high.
- R8: `slave_drive` is high only while `bus_ack` is high during a read. It never overlaps the initiator driving write data.
- R9: `xfer_done` is a single-cycle pulse per transfer. `cmd_ready` is high only while the initiator is idle.
- R10: After reset, `bus_req`, `bus_ack`, `addr_drive`, `slave_drive` and `xfer_done` are low, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both controllers |
| rst | input | 1 | Synchronous active-high reset |
| own_bus | input | 1 | Initiator currently owns the bus |
| cmd_valid | input | 1 | Start a transfer |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target register address |
| cmd_wdata | input | DATA_W | Word to write |
| cmd_ready | output | 1 | Initiator idle, command may be given |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_rdata | output | DATA_W | Read word, valid with xfer_done |
| bus_req | output | 1 | Request wire |
| bus_ack | output | 1 | Acknowledge wire |
| bus_write | output | 1 | Direction wire while driven |
| addr_drive | output | 1 | Initiator drives address and direction |
| slave_drive | output | 1 | Responder drives the data lines |

## Verification
Every register address is written in ascending order with one arithmetic pattern and read back. All addresses are then rewritten in descending order with a second, bit-inverted pattern and read again. The two passes separate stale, aliased or mis-addressed storage from correct storage. On every transfer, the edges of request, acknowledge and the two drive enables are timed at the ports. This shows whether the settle interval is exact and whether each of the four phases waits for its predecessor. A command held while ownership is absent, followed by a read of the same address, tells an ignored command apart from one that leaked through.

// File: rtl/rtz_link_pkg.sv
package rtz_link_pkg;
  typedef enum logic [1:0] {
    MST_IDLE   = 2'd0,
    MST_SETTLE = 2'd1,
    MST_WAIT_A = 2'd2,
    MST_WAIT_N = 2'd3
  } mst_state_t;

  typedef enum logic {
    SLV_IDLE  = 1'b0,
    SLV_HELD  = 1'b1
  } slv_state_t;
endpackage

// File: rtl/rtz_sync.sv
module rtz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rtz_regfile.sv
module rtz_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rtz_initiator.sv
module rtz_initiator
  import rtz_link_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int DECODE_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              own_bus,
  input  logic              start,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              ack_in,
  input  logic [DATA_W-1:0] bus_din,
  output logic              ready,
  output logic              req,
  output logic              drv,
  output logic              wdata_en,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int CNT_W = (DECODE_CYC > 1) ? $clog2(DECODE_CYC) : 1;

  mst_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              ack_s;

  rtz_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_in), .q(ack_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= MST_IDLE;
      cnt     <= '0;
      req     <= 1'b0;
      drv     <= 1'b0;
      wr_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        MST_IDLE: begin
          if (start && own_bus) begin
            drv     <= 1'b1;
            wr_o    <= start_wr;
            addr_o  <= start_addr;
            wdata_o <= start_wdata;
            cnt     <= '0;
            state   <= MST_SETTLE;
          end
        end
        MST_SETTLE: begin
          if (cnt == CNT_W'(DECODE_CYC - 1)) begin
            req   <= 1'b1;
            state <= MST_WAIT_A;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        MST_WAIT_A: begin
          if (ack_s) begin
            if (!wr_o) rdata <= bus_din;
            req   <= 1'b0;
            state <= MST_WAIT_N;
          end
        end
        MST_WAIT_N: begin
          if (!ack_s) begin
            drv   <= 1'b0;
            wr_o  <= 1'b0;
            done  <= 1'b1;
            state <= MST_IDLE;
          end
        end
        default: state <= MST_IDLE;
      endcase
    end
  end

  assign ready    = (state == MST_IDLE);
  assign wdata_en = drv & wr_o;

  // checker: cycles the address has been driven without request
  int settle_cnt;
  always_ff @(posedge clk) begin
    if (rst || !drv) settle_cnt <= 0;
    else if (!req)   settle_cnt <= settle_cnt + 1;
  end

  a_r2_settle_exact: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> (settle_cnt == DECODE_CYC));
  a_r5_req_fall_after_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> $past(ack_s));
  a_r7_no_drive_under_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(drv) |-> !$past(ack_s));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/rtz_responder.sv
module rtz_responder
  import rtz_link_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_in,
  input  logic              wr_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              ack,
  output logic              dout_en,
  output logic [DATA_W-1:0] dout
);
  slv_state_t state;
  logic       req_s;
  logic       take;

  rtz_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_in), .q(req_s)
  );

  assign take = (state == SLV_IDLE) && req_s;

  rtz_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk(clk),
    .we(take && wr_in),
    .waddr(addr_in),
    .wdata(data_in),
    .re(take && !wr_in),
    .raddr(addr_in),
    .rdata(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SLV_IDLE;
      ack     <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      unique case (state)
        SLV_IDLE: begin
          if (req_s) begin
            ack     <= 1'b1;
            dout_en <= !wr_in;
            state   <= SLV_HELD;
          end
        end
        SLV_HELD: begin
          if (!req_s) begin
            ack     <= 1'b0;
            dout_en <= 1'b0;
            state   <= SLV_IDLE;
          end
        end
        default: state <= SLV_IDLE;
      endcase
    end
  end

  a_r3_ack_after_req: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(req_s));
  a_r6_ack_fall_after_req: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> !$past(req_s));
  a_r8_dout_only_read_ack: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> (ack && !wr_in));
endmodule

// File: rtl/rtz_link_top.sv
module rtz_link_top #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int DECODE_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              own_bus,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              xfer_done,
  output logic [DATA_W-1:0] xfer_rdata,
  output logic              bus_req,
  output logic              bus_ack,
  output logic              bus_write,
  output logic              addr_drive,
  output logic              slave_drive
);
  logic              m_wen;
  logic              m_wr;
  logic [ADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_wdata;
  logic [DATA_W-1:0] s_dout;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;

  assign bus_addr  = addr_drive ? m_addr : '0;
  assign bus_write = addr_drive & m_wr;
  assign bus_data  = m_wen ? m_wdata : (slave_drive ? s_dout : '0);

  rtz_initiator #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DECODE_CYC(DECODE_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_init (
    .clk(clk), .rst(rst), .own_bus(own_bus),
    .start(cmd_valid), .start_wr(cmd_write),
    .start_addr(cmd_addr), .start_wdata(cmd_wdata),
    .ack_in(bus_ack), .bus_din(bus_data),
    .ready(cmd_ready), .req(bus_req), .drv(addr_drive),
    .wdata_en(m_wen), .wr_o(m_wr), .addr_o(m_addr),
    .wdata_o(m_wdata), .done(xfer_done), .rdata(xfer_rdata)
  );

  rtz_responder #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_resp (
    .clk(clk), .rst(rst), .req_in(bus_req), .wr_in(bus_write),
    .addr_in(bus_addr), .data_in(bus_data),
    .ack(bus_ack), .dout_en(slave_drive), .dout(s_dout)
  );

  a_r8_no_data_collision: assert property (@(posedge clk) disable iff (rst)
    !(m_wen && slave_drive));
  a_r1_idle_without_owner: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && !own_bus) |=> !addr_drive);
endmodule

// File: tb/tb_rtz_link_top.sv
module tb_rtz_link_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int DECODE_CYC = 2;
  localparam int DEPTH      = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic own_bus = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_write = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic cmd_ready, xfer_done, bus_req, bus_ack, bus_write, addr_drive, slave_drive;
  logic [DATA_W-1:0] xfer_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  logic [DATA_W-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtz_link_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DECODE_CYC(DECODE_CYC)) dut (
    .clk(clk), .rst(rst), .own_bus(own_bus), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_ready(cmd_ready), .xfer_done(xfer_done), .xfer_rdata(xfer_rdata),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_write(bus_write),
    .addr_drive(addr_drive), .slave_drive(slave_drive)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  // protocol monitor, sampled on the falling edge
  logic p_req = 0, p_ack = 0, p_drv = 0, p_done = 0, p_sdrv = 0;
  int   drv_cnt = 0;
  bit   mon_on = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (bus_req && !p_req) begin
        chk(drv_cnt == DECODE_CYC, "R2 settle cycles", drv_cnt, DECODE_CYC);
        chk(!bus_ack, "R6 req rise with ack low", bus_ack, 0);
      end
      if (!bus_req && p_req)  chk(bus_ack, "R5 req fall with ack high", bus_ack, 1);
      if (bus_ack && !p_ack)  chk(bus_req, "R3 ack rise with req high", bus_req, 1);
      if (!bus_ack && p_ack)  chk(!bus_req, "R6 ack fall with req low", bus_req, 0);
      if (addr_drive && !p_drv) chk(!bus_ack, "R7 new drive with ack low", bus_ack, 0);
      if (!addr_drive && p_drv) chk(!bus_ack && !bus_req, "R7 release after ack low", bus_ack, 0);
      if (slave_drive && !p_sdrv)
        chk(bus_ack && !bus_write, "R8 slave drive only on read ack", {bus_ack, bus_write}, 2);
      if (slave_drive) chk(bus_ack && !bus_write, "R8 slave drive held", {bus_ack, bus_write}, 2);
      if (xfer_done) begin
        chk(!p_done, "R9 done single cycle", p_done, 0);
        chk(!bus_ack, "R7 done after ack low", bus_ack, 0);
      end
      if (p_done && !xfer_done) chk(cmd_ready, "R9 ready after done", cmd_ready, 1);
      if (addr_drive) chk(!cmd_ready, "R9 ready low while busy", cmd_ready, 0);
    end
    if (!addr_drive) drv_cnt = 0;
    else if (!bus_req) drv_cnt = drv_cnt + 1;
    p_req = bus_req; p_ack = bus_ack; p_drv = addr_drive;
    p_done = xfer_done; p_sdrv = slave_drive;
  end

  task automatic xfer(input bit wr, input int a, input int d, output int rd);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a[ADDR_W-1:0]; cmd_wdata = d[DATA_W-1:0];
    @(negedge clk);
    cmd_valid = 0;
    while (!xfer_done) @(negedge clk);
    rd = int'(xfer_rdata);
  endtask

  initial begin
    int w;
    for (w = 0; w < 100000; w++) @(posedge clk);
    chk(0, "watchdog expired", w, 0);
    finish_run();
  end

  initial begin
    int rd;
    bit leak;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(!bus_req && !bus_ack && !addr_drive && !slave_drive && !xfer_done,
        "R10 control low after reset",
        {bus_req, bus_ack, addr_drive, slave_drive, xfer_done}, 0);
    chk(cmd_ready, "R10 ready after reset", cmd_ready, 1);
    mon_on = 1;
    own_bus = 1;

    // pass 1: ascending writes, pattern a*13+7
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = DATA_W'(a * 13 + 7);
      xfer(1, a, int'(model[a]), rd);
    end
    for (int a = 0; a < DEPTH; a++) begin
      xfer(0, a, 0, rd);
      chk(rd == int'(model[a]), "R4 read pass1", rd, int'(model[a]));
    end
    // pass 2: descending writes, inverted pattern
    for (int a = DEPTH - 1; a >= 0; a--) begin
      model[a] = ~DATA_W'(a * 29 + 3);
      xfer(1, a, int'(model[a]), rd);
    end
    for (int a = DEPTH - 1; a >= 0; a--) begin
      xfer(0, a, 0, rd);
      chk(rd == int'(model[a]), "R3 R4 read pass2", rd, int'(model[a]));
    end

    // R1: command held without ownership is ignored
    @(negedge clk);
    own_bus = 0;
    cmd_valid = 1; cmd_write = 1; cmd_addr = 3; cmd_wdata = ~model[3];
    leak = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (addr_drive || bus_req) leak = 1;
    end
    chk(!leak, "R1 no drive without ownership", leak, 0);
    cmd_valid = 0;
    @(negedge clk);
    own_bus = 1;
    xfer(0, 3, 0, rd);
    chk(rd == int'(model[3]), "R1 register unchanged", rd, int'(model[3]));

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule